// File: doc/BRIEF.md
# Multiplexed LED Matrix Serial Scanner

This block refreshes a multiplexed LED array made of six 5×7 dot-matrix displays, grouped logically as two display rows of three displays each. The fifteen columns of the array are the five pixel columns of each display in a logical row. Each column carries fourteen row bits: seven for the upper display row, then seven for the lower one. A host loads the pixel pattern into a small column frame buffer through a plain write port (address, data, enable). The block reads that buffer on its own schedule, so the host never has to time its writes to the scan.

A divider, set by a parameter, turns the system clock into a periodic scan tick. The nominal rate is 15 kHz, which refreshes the whole array at 1 kHz. On each tick the block builds one 32-bit word. The word holds a one-hot select for the current column and the fourteen row bits of that column. The block shifts the word out MSB first over a mode-0 serial link (clock, data, active-low select) to external shift-register drivers. The rising edge of the select line latches the shifted word into the drivers. The column then advances by one and wraps after the fifteenth.

Top module: `led_scan_spi`

## Requirements
- R1: While `rst` is high, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0, and no transfer begins.
- R2: Exactly one transfer starts per scan tick, so successive falling edges of `spi_cs_n` are `TICK_DIV` clock cycles apart.
- R3: Each transfer has exactly 32 rising edges of `spi_sclk`, sent MSB first. `spi_sclk` idles low, and `spi_mosi` changes only while `spi_sclk` is low (mode 0).
- R4: Bits 31..29 of every word are 0.
- R5: Bits 28..14 of every word are one-hot, with exactly one bit set.
- R6: The selected column is bit 14+c for column c. The first word after reset selects column 0. Each later word selects the next column, and column 14 is followed by column 0.
- R7: Bits 13..0 of the word for column c equal frame entry c. Bit 0 is the top pixel of the upper display row, and bit 7 is the top pixel of the lower display row.
- R8: A write with `wr_en`=1 and `wr_addr` in 0..14 replaces that frame entry. A write to address 15 changes no entry.
- R9: The word is captured when its transfer starts. A write to the column being sent does not alter the word in flight and appears on the next visit to that column.
- R10: `spi_cs_n` rises only together with the last falling edge of `spi_sclk`. The select-low window lasts 64·`SCLK_HALF` cycles, which is shorter than one tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Frame buffer write strobe |
| wr_addr | input | 4 | Column index to write (0..14) |
| wr_data | input | 14 | Row pixels for that column |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low select; rising edge latches the drivers |

## Verification
The bench builds the block with `TICK_DIV`=200 and `SCLK_HALF`=2. With these values a 129-cycle transfer fits inside a 200-cycle tick, and 35 words take only a few thousand cycles. That brings more than two full column sweeps within reach, so the wrap from column 14 back to 0 and every frame entry are decoded and compared against arithmetic expectations. The short tick also makes it cheap to aim a frame write at the column in flight, and to write the out-of-range address 15 before the sweeps begin.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int COL_N  = 15;
    localparam int ROW_N  = 14;
    localparam int PAD_N  = 3;
    localparam int WORD_W = PAD_N + COL_N + ROW_N;
    localparam int COL_AW = $clog2(COL_N + 1);

    typedef struct packed {
        logic [PAD_N-1:0] pad;
        logic [COL_N-1:0] col_sel;
        logic [ROW_N-1:0] rows;
    } scan_word_t;

    function automatic logic [COL_N-1:0] col_onehot(input logic [COL_AW-1:0] idx);
        logic [COL_N-1:0] v;
        v = '0;
        for (int i = 0; i < COL_N; i++) begin
            if (idx == COL_AW'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic scan_word_t build_word(input logic [COL_AW-1:0] idx,
                                              input logic [ROW_N-1:0]  rows);
        scan_word_t w;
        w.pad     = '0;
        w.col_sel = col_onehot(idx);
        w.rows    = rows;
        return w;
    endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int DIV = 6667
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/col_frame_mem.sv
module col_frame_mem
    import led_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [COL_AW-1:0] wr_addr,
    input  logic [ROW_N-1:0]  wr_data,
    input  logic [COL_AW-1:0] rd_addr,
    output logic [ROW_N-1:0]  rd_data
);
    logic [ROW_N-1:0] entry [COL_N];

    for (genvar e = 0; e < COL_N; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[e] <= '0;
            end else if (wr_en && (wr_addr == COL_AW'(e))) begin
                entry[e] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < COL_N; i++) begin
            if (rd_addr == COL_AW'(i)) rd_data = entry[i];
        end
    end
endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx
    import led_scan_pkg::*;
#(
    parameter int HALF = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(WORD_W);

    logic [WORD_W-1:0] shadow;
    logic [HW-1:0]     hcnt;
    logic [BW-1:0]     bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            shadow <= '0;
            hcnt   <= '0;
            bitcnt <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                cs_n   <= 1'b0;
                sclk   <= 1'b0;
                shadow <= word;
                hcnt   <= '0;
                bitcnt <= '0;
            end
        end else if (hcnt == HW'(HALF - 1)) begin
            hcnt <= '0;
            if (!sclk) begin
                sclk <= 1'b1;
            end else begin
                sclk <= 1'b0;
                if (bitcnt == BW'(WORD_W - 1)) begin
                    busy <= 1'b0;
                    cs_n <= 1'b1;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                    shadow <= {shadow[WORD_W-2:0], 1'b0};
                end
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign mosi = busy & shadow[WORD_W-1];
endmodule

// File: rtl/led_scan_spi.sv
module led_scan_spi
    import led_scan_pkg::*;
#(
    parameter int TICK_DIV  = 6667,
    parameter int SCLK_HALF = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [13:0] wr_data,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n
);
    logic              tick;
    logic              busy;
    logic              start;
    logic [COL_AW-1:0] col_idx;
    logic [ROW_N-1:0]  col_rows;
    scan_word_t        word;

    scan_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    col_frame_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (col_idx),
        .rd_data (col_rows)
    );

    assign start = tick & ~busy;
    assign word  = build_word(col_idx, col_rows);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_idx <= '0;
        end else if (start) begin
            col_idx <= (col_idx == COL_AW'(COL_N - 1)) ? '0 : col_idx + 1'b1;
        end
    end

    spi_word_tx #(.HALF(SCLK_HALF)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .word  (word),
        .busy  (busy),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
    parameter int NUM_COLS = 15
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_cs_n,
    input logic       start,
    input logic [3:0] col_idx
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs idle during reset
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_idle: assert (spi_cs_n && !spi_sclk && !spi_mosi);
        end
    end

    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    a_r4_mosi_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_mosi);

    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    a_r10_cs_rise_with_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> $fell(spi_sclk));

    a_r6_col_in_range: assert property (@(posedge clk) disable iff (rst)
        col_idx < 4'(NUM_COLS));

    a_r6_col_moves_on_start: assert property (@(posedge clk) disable iff (rst)
        (col_idx != $past(col_idx)) |-> $past(start));

    a_r2_start_opens_select: assert property (@(posedge clk) disable iff (rst)
        start |=> !spi_cs_n);
endmodule

bind led_scan_spi led_scan_chk #(.NUM_COLS(led_scan_pkg::COL_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .start    (start),
    .col_idx  (col_idx)
);

// File: tb/test_led_scan_spi.sv
module test_led_scan_spi;
    localparam int TDIV  = 200;
    localparam int HALF  = 2;
    localparam int NWORD = 35;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        spi_sclk, spi_mosi, spi_cs_n;

    int errors = 0;
    int checks = 0;

    led_scan_spi #(.TICK_DIV(TDIV), .SCLK_HALF(HALF)) i_led_scan_spi (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;

    logic [13:0] exp_fb [15];
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [13:0] pat(input int c);
        return 14'((c * 1237 + 341) & 16'h3FFF);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [13:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd15) exp_fb[a] = d;
    endtask

    // serial monitor
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b1;
    logic [31:0] rx = '0;
    int          nbits = 0;
    int          words = 0;
    int          falls = 0;
    int          exp_col = 0;
    int          fall_cyc = 0;
    logic [13:0] snap;

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sclk && !prev_sclk) begin
                rx = {rx[30:0], spi_mosi};
                nbits++;
            end
            if (!spi_cs_n && prev_cs) begin
                if (falls > 0) chk(cyc - fall_cyc == TDIV, "R2 tick spacing", cyc - fall_cyc, TDIV);
                fall_cyc = cyc;
                falls++;
                nbits = 0;
                snap = exp_fb[exp_col];
            end
            if (spi_cs_n && !prev_cs) begin
                chk(nbits == 32, "R3 sclk rises per word", nbits, 32);
                chk(rx[31:29] == 3'b000, "R4 pad bits", rx[31:29], 0);
                chk($countones(rx[28:14]) == 1, "R5 column one-hot", rx[28:14], 15'(1 << exp_col));
                chk(rx[28:14] == 15'(1 << exp_col), "R6 column order", rx[28:14], 15'(1 << exp_col));
                chk(rx[13:0] == snap, "R7 R8 R9 row field", rx[13:0], snap);
                chk((cyc - fall_cyc == 64 * HALF) && prev_sclk && !spi_sclk,
                    "R10 latch timing", cyc - fall_cyc, 64 * HALF);
                words++;
                exp_col = (exp_col == 14) ? 0 : exp_col + 1;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    initial begin
        for (int c = 0; c < 15; c++) exp_fb[c] = '0;
        // R1: reset holds outputs idle; write during reset is ignored
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 14'h3FFF;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(spi_cs_n && !spi_sclk && !spi_mosi, "R1 reset idle",
                {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        end
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R8: fill entries, then an out-of-range write
        for (int c = 0; c < 15; c++) host_write(4'(c), pat(c));
        host_write(4'd15, 14'h2AAA);
        // R9: write to the column in flight during word 19 (column 4)
        while (falls < 20) @(negedge clk);
        repeat (10) @(negedge clk);
        host_write(4'd4, 14'h1234);
        while (words < NWORD) @(negedge clk);
        chk(words == NWORD, "R6 word count", words, NWORD);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", words, NWORD);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule